// File: doc/BRIEF.md
# Two-Strobe DRAM Array Model

A synthesizable behavioural model of a small dynamic memory. The storage is a square grid of byte-wide supercells. A narrow address bus carries first a row index and then a column index. A row-activate strobe copies one whole row of the grid into an internal row buffer. Column strobes then read or write single bytes of that buffer. A precharge strobe writes the buffer back into the grid and closes the row.

A free-running timer asks for refresh at a fixed interval. While the refresh runs, a busy flag is high and new row activations are turned away. The refresh only makes progress while no row is open. The controller side drives one-cycle strobes and watches the error, busy and read-valid flags.

Top module: `mux_dram`

## Requirements
- R1: After reset, rdata_o, rvalid_o, err_o, ref_req_o and busy_o are all 0, and every supercell of the grid reads back as 0.
- R2: A row strobe (ras_i) with address i opens row i. A later read column strobe (cas_i=1, we_i=0) with address j drives supercell (i, j) on rdata_o, with rvalid_o=1, in the cycle after the strobe.
- R3: rdata_o and rvalid_o hold their values until the next strobe of any kind, and any strobe clears rvalid_o in the following cycle unless that strobe is a read to an open row.
- R4: A write column strobe (cas_i=1, we_i=1) updates byte j of the row buffer with wdata_i. Column accesses may follow each other on consecutive cycles, and a read sees all earlier writes to the open row.
- R5: A precharge strobe (pre_i) writes the whole row buffer back to the open row and closes it. Rows that were not open keep their contents.
- R6: A column strobe with no open row has no effect on the data, and err_o is 1 for exactly the following cycle.
- R7: A row strobe while a row is already open is ignored, so the open row and its buffer are kept.
- R8: When strobes coincide, precedence is pre_i, then ras_i, then cas_i. The losing strobes in that cycle are ignored and raise no error.
- R9: ref_req_o is a one-cycle pulse that repeats every REF_PERIOD clock cycles.
- R10: busy_o rises together with ref_req_o. It then stays high until REF_BURST cycles have passed with no row open, and a row strobe is ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Row index with ras_i, column index with cas_i |
| ras_i | input | 1 | Row activate strobe |
| cas_i | input | 1 | Column strobe |
| we_i | input | 1 | With cas_i: 1 write, 0 read |
| pre_i | input | 1 | Precharge (write back and close) strobe |
| wdata_i | input | DW | Write byte |
| rdata_o | output | DW | Read byte |
| rvalid_o | output | 1 | rdata_o holds a read result |
| err_o | output | 1 | Column strobe arrived with no open row |
| ref_req_o | output | 1 | Refresh request pulse |
| busy_o | output | 1 | Refresh in progress |

## Verification
A wrong row latched at activation shows up on the first read as data from the wrong row, one cycle after the column strobe. A lost write-back is only seen after the row is precharged and opened again, when reads return stale bytes. A stuck open-row flag shows up on the next column strobe, either as a missing err_o or as a spurious one. A wrong refresh counter or burst counter can be seen within one refresh interval, as a wrong gap between ref_req_o pulses or a wrong length of busy_o.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_PRE,
    CMD_ACT,
    CMD_RD,
    CMD_WR
  } dram_cmd_e;

  // precedence: precharge, activate, column
  function automatic dram_cmd_e decode_cmd(input logic ras, input logic cas,
                                           input logic pre, input logic we);
    if (pre)      return CMD_PRE;
    else if (ras) return CMD_ACT;
    else if (cas) return we ? CMD_WR : CMD_RD;
    else          return CMD_NOP;
  endfunction
endpackage

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 8,
  localparam int RAW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int ROW_W = COLS * DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RAW-1:0]   rd_row_i,
  output logic [ROW_W-1:0] rd_data_o,
  input  logic             wr_en_i,
  input  logic [RAW-1:0]   wr_row_i,
  input  logic [ROW_W-1:0] wr_data_i
);
  logic [ROW_W-1:0] rows_w [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [ROW_W-1:0] row_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) row_q <= '0;
      else if (wr_en_i && wr_row_i == RAW'(r)) row_q <= wr_data_i;
    end
    assign rows_w[r] = row_q;
  end

  assign rd_data_o = rows_w[rd_row_i];
endmodule

// File: rtl/dram_row_buf.sv
module dram_row_buf #(
  parameter int COLS = 4,
  parameter int DW   = 8,
  localparam int CAW   = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int ROW_W = COLS * DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ROW_W-1:0] load_data_i,
  input  logic             wr_i,
  input  logic [CAW-1:0]   col_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [ROW_W-1:0] row_o,
  output logic [DW-1:0]    col_data_o
);
  logic [DW-1:0] bytes_w [COLS];

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [DW-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         byte_q <= '0;
      else if (load_i)                     byte_q <= load_data_i[c*DW +: DW];
      else if (wr_i && col_i == CAW'(c))   byte_q <= wdata_i;
    end
    assign bytes_w[c] = byte_q;
    assign row_o[c*DW +: DW] = byte_q;
  end

  assign col_data_o = bytes_w[col_i];
endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int REF_PERIOD = 3_200_000,
  parameter int REF_BURST  = 4,
  localparam int CW = $clog2(REF_PERIOD),
  localparam int BW = (REF_BURST > 1) ? $clog2(REF_BURST) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic row_open_i,
  output logic req_o,
  output logic busy_o
);
  localparam logic [CW-1:0] CNT_LAST   = CW'(REF_PERIOD - 1);
  localparam logic [BW-1:0] BURST_LAST = BW'(REF_BURST - 1);

  logic [CW-1:0] cnt_q;
  logic [BW-1:0] burst_q;
  logic          expire;

  assign expire = (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      req_o   <= 1'b0;
      busy_o  <= 1'b0;
      burst_q <= '0;
    end else begin
      cnt_q <= expire ? '0 : cnt_q + 1'b1;
      req_o <= expire;
      if (expire) begin
        busy_o  <= 1'b1;
        burst_q <= '0;
      end else if (busy_o && !row_open_i) begin
        // refresh only advances with the bank precharged
        if (burst_q == BURST_LAST) busy_o <= 1'b0;
        else                       burst_q <= burst_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mux_dram.sv
module mux_dram
  import dram_pkg::*;
#(
  parameter int ROWS       = 4,
  parameter int COLS       = 4,
  parameter int DW         = 8,
  parameter int REF_PERIOD = 3_200_000,
  parameter int REF_BURST  = 4,
  localparam int RAW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CAW = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int AW  = (RAW > CAW) ? RAW : CAW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          ras_i,
  input  logic          cas_i,
  input  logic          we_i,
  input  logic          pre_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          err_o,
  output logic          ref_req_o,
  output logic          busy_o
);
  localparam int ROW_W = COLS * DW;

  dram_cmd_e        cmd;
  logic             row_open_q;
  logic [RAW-1:0]   open_row_q;
  logic             act_ok, col_ok, col_cmd, wr_back;
  logic [ROW_W-1:0] arr_row, buf_row;
  logic [DW-1:0]    buf_byte;

  assign cmd     = decode_cmd(ras_i, cas_i, pre_i, we_i);
  assign col_cmd = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign col_ok  = col_cmd && row_open_q;
  assign act_ok  = (cmd == CMD_ACT) && !row_open_q && !busy_o;
  assign wr_back = (cmd == CMD_PRE) && row_open_q;

  dram_cell_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_row_i (addr_i[RAW-1:0]),
    .rd_data_o(arr_row),
    .wr_en_i  (wr_back),
    .wr_row_i (open_row_q),
    .wr_data_i(buf_row)
  );

  dram_row_buf #(.COLS(COLS), .DW(DW)) u_rbuf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (act_ok),
    .load_data_i(arr_row),
    .wr_i       (col_ok && cmd == CMD_WR),
    .col_i      (addr_i[CAW-1:0]),
    .wdata_i    (wdata_i),
    .row_o      (buf_row),
    .col_data_o (buf_byte)
  );

  dram_refresh_timer #(.REF_PERIOD(REF_PERIOD), .REF_BURST(REF_BURST)) u_ref (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .row_open_i(row_open_q),
    .req_o     (ref_req_o),
    .busy_o    (busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_open_q <= 1'b0;
      open_row_q <= '0;
      rdata_o    <= '0;
      rvalid_o   <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      err_o <= col_cmd && !row_open_q;
      if (cmd != CMD_NOP) rvalid_o <= 1'b0;
      if (col_ok && cmd == CMD_RD) begin
        rvalid_o <= 1'b1;
        rdata_o  <= buf_byte;
      end
      if (wr_back) row_open_q <= 1'b0;
      if (act_ok) begin
        row_open_q <= 1'b1;
        open_row_q <= addr_i[RAW-1:0];
      end
    end
  end
endmodule

// File: rtl/dram_chk.sv
module dram_chk #(
  parameter int AW = 2,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          ras_i,
  input logic          cas_i,
  input logic          we_i,
  input logic          pre_i,
  input logic [DW-1:0] rdata_o,
  input logic          rvalid_o,
  input logic          err_o,
  input logic          ref_req_o,
  input logic          busy_o
);
  a_r2_valid_from_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rvalid_o) |-> $past(cas_i && !we_i && !ras_i && !pre_i));

  a_r3_rdata_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && $past(rvalid_o) && !$past(cas_i)) |-> $stable(rdata_o));

  a_r6_err_from_cas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(cas_i && !ras_i && !pre_i));

  a_r6_err_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !rvalid_o);

  a_r9_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o |=> !ref_req_o);

  a_r10_req_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o |-> busy_o);

  // addr_i is bound for waveform context only
  logic unused_addr;
  assign unused_addr = ^addr_i;
endmodule

bind mux_dram dram_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .ras_i    (ras_i),
  .cas_i    (cas_i),
  .we_i     (we_i),
  .pre_i    (pre_i),
  .rdata_o  (rdata_o),
  .rvalid_o (rvalid_o),
  .err_o    (err_o),
  .ref_req_o(ref_req_o),
  .busy_o   (busy_o)
);

// File: tb/sim_mux_dram.sv
module sim_mux_dram;
  localparam int PER   = 400;
  localparam int BURST = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       ras = 1'b0, cas = 1'b0, we = 1'b0, pre = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rvalid, err, ref_req, busy;

  int nchk = 0, nfail = 0, cyc = 0;
  logic [7:0] arr_m [4][4];
  logic [7:0] buf_m [4];
  int         open_m = -1;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mux_dram #(.REF_PERIOD(PER), .REF_BURST(BURST)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .ras_i(ras), .cas_i(cas),
    .we_i(we), .pre_i(pre), .wdata_i(wdata), .rdata_o(rdata),
    .rvalid_o(rvalid), .err_o(err), .ref_req_o(ref_req), .busy_o(busy)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // caller is at a negedge; returns at the negedge after the sampling edge
  task automatic strobe(input logic r, input logic c, input logic p, input logic w,
                        input logic [1:0] a, input logic [7:0] d);
    ras = r; cas = c; pre = p; we = w; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    ras = 0; cas = 0; pre = 0; we = 0;
  endtask

  task automatic open_row(input int r);
    while (busy) @(negedge clk);
    strobe(1, 0, 0, 0, 2'(r), 8'h0);
    open_m = r;
    for (int c = 0; c < 4; c++) buf_m[c] = arr_m[r][c];
  endtask

  task automatic close_row();
    strobe(0, 0, 1, 0, 2'd0, 8'h0);
    if (open_m >= 0) for (int c = 0; c < 4; c++) arr_m[open_m][c] = buf_m[c];
    open_m = -1;
  endtask

  task automatic wr_col(input int c, input logic [7:0] d);
    strobe(0, 1, 0, 1, 2'(c), d);
    buf_m[c] = d;
  endtask

  task automatic rd_col(input string req, input int c);
    strobe(0, 1, 0, 0, 2'(c), 8'h0);
    chk(req, "rvalid", int'(rvalid), 1);
    chk(req, $sformatf("data col %0d", c), int'(rdata), int'(buf_m[c]));
  endtask

  task automatic t_reset();
    chk("R1", "rdata", int'(rdata), 0);
    chk("R1", "rvalid", int'(rvalid), 0);
    chk("R1", "err", int'(err), 0);
    chk("R1", "ref_req", int'(ref_req), 0);
    chk("R1", "busy", int'(busy), 0);
    for (int r = 0; r < 4; r++) begin
      open_row(r);
      for (int c = 0; c < 4; c++) rd_col("R1", c);
      close_row();
    end
  endtask

  task automatic t_fill();
    for (int r = 0; r < 4; r++) begin
      open_row(r);
      for (int c = 0; c < 4; c++) wr_col(c, 8'(8'h5a ^ (r * 37 + c * 11)));
      for (int c = 3; c >= 0; c--) rd_col("R4", c);
      close_row();
    end
    for (int r = 3; r >= 0; r--) begin
      open_row(r);
      for (int c = 0; c < 4; c++) rd_col("R2", c);
      close_row();
    end
    // rewrite one byte of row 2, row 1 must be unaffected
    open_row(2);
    wr_col(1, 8'hc3);
    rd_col("R4", 1);
    wr_col(1, 8'h3c);
    rd_col("R4", 1);
    close_row();
    open_row(2);
    rd_col("R5", 1);
    close_row();
    open_row(1);
    for (int c = 0; c < 4; c++) rd_col("R5", c);
    close_row();
  endtask

  task automatic t_hold();
    logic [7:0] exp_d;
    open_row(3);
    rd_col("R3", 2);
    exp_d = buf_m[2];
    repeat (3) @(negedge clk);
    chk("R3", "rvalid held", int'(rvalid), 1);
    chk("R3", "rdata held", int'(rdata), int'(exp_d));
    wr_col(0, 8'h77);
    chk("R3", "rvalid after write", int'(rvalid), 0);
    close_row();
  endtask

  task automatic t_err();
    strobe(0, 1, 0, 0, 2'd2, 8'h0);
    chk("R6", "err on read w/o row", int'(err), 1);
    chk("R6", "rvalid", int'(rvalid), 0);
    @(negedge clk);
    chk("R6", "err one cycle", int'(err), 0);
    strobe(0, 1, 0, 1, 2'd0, 8'hee);
    chk("R6", "err on write w/o row", int'(err), 1);
    open_row(0);
    rd_col("R6", 0);
    close_row();
  endtask

  task automatic t_ras_open();
    open_row(1);
    strobe(1, 0, 0, 0, 2'd3, 8'h0);
    for (int c = 0; c < 4; c++) rd_col("R7", c);
    close_row();
  endtask

  task automatic t_prio();
    open_row(0);
    wr_col(3, 8'h9d);
    strobe(0, 1, 1, 1, 2'd3, 8'h11);  // pre wins, write dropped
    for (int c = 0; c < 4; c++) arr_m[0][c] = buf_m[c];
    open_m = -1;
    chk("R8", "no err with pre", int'(err), 0);
    chk("R8", "no rvalid with pre", int'(rvalid), 0);
    strobe(0, 1, 0, 0, 2'd3, 8'h0);
    chk("R8", "row closed by pre", int'(err), 1);
    while (busy) @(negedge clk);
    strobe(1, 1, 0, 0, 2'd0, 8'h0);  // ras wins over cas
    open_m = 0;
    for (int c = 0; c < 4; c++) buf_m[c] = arr_m[0][c];
    chk("R8", "no rvalid with ras", int'(rvalid), 0);
    chk("R8", "no err with ras", int'(err), 0);
    rd_col("R8", 3);
    close_row();
  endtask

  task automatic t_refresh();
    int t1, t2, n;
    while (!ref_req) @(negedge clk);
    t1 = cyc;
    chk("R10", "busy with req", int'(busy), 1);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R10", "busy length, bank idle", n, BURST);
    while (!ref_req) @(negedge clk);
    t2 = cyc;
    chk("R9", "refresh interval", t2 - t1, PER);
    strobe(1, 0, 0, 0, 2'd2, 8'h0);   // blocked by busy
    @(negedge clk);
    chk("R9", "req single cycle", int'(ref_req), 0);
    while (busy) @(negedge clk);
    strobe(0, 1, 0, 0, 2'd1, 8'h0);
    chk("R10", "ras ignored while busy", int'(err), 1);
    open_row(2);
    while (!ref_req) @(negedge clk);
    repeat (10) @(negedge clk);
    chk("R10", "busy held with row open", int'(busy), 1);
    close_row();
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R10", "busy length after close", n, BURST);
  endtask

  initial begin
    for (int r = 0; r < 4; r++) for (int c = 0; c < 4; c++) arr_m[r][c] = 8'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_hold();
    t_err();
    t_ras_open();
    t_prio();
    t_refresh();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule